// File: doc/BRIEF.md
# Synchronous Burst Memory Controller with Wait Handling

This block runs burst reads and burst writes against a clocked memory such as a pseudo-static RAM or a burst flash. A request (address, direction, length code) is taken while the controller is idle. The controller then lowers chip select, pulses address-valid low for one cycle so the memory latches the address, and waits a programmed initial latency. After that it streams data beats, signalling each read beat on `beat_valid` and each write beat on `beat_ready`. The memory clock output toggles only while an access is open.

The memory stalls the burst with an active-low wait line. It raises that line one cycle early, and the controller passes it through a two-flop synchronizer before it gates the beat counter. The initial latency is set separately for reads (`cfg_trc`) and writes (`cfg_twc`) so that the synchronized wait is stable before the first beat can be taken. For a wait-enabled read this is normally three cycles plus the output-enable delay, and three cycles for a write. A length code selects a fixed beat count or an open-ended burst that runs until the requester drops `req_valid`.

Top module: `sync_burst_ctrl`

## Requirements
- R1: After reset, and whenever idle, `mem_cs_n`, `mem_adv_n`, `mem_oe_n` and `mem_we_n` are high, `beat_valid`, `beat_ready` and `burst_done` are low, and `mem_clk` stays low.
- R2: `mem_clk` is high during the high phase of `clk` only when the cycle that phase closes was an open access (`mem_cs_n` low). Otherwise it is held low.
- R3: A request seen with `req_valid` high while idle opens an access on the next edge. In the first cycle of `mem_cs_n` low, `mem_adv_n` is low for exactly that one cycle.
- R4: On a read, `mem_oe_n` is low from the second cycle of the access until it closes, and `mem_we_n` stays high. Beats appear only on `beat_valid`, and never before cycle index max(`cfg_trc`,1) counted from 0 at the first cycle of `mem_cs_n` low.
- R5: On a write, `mem_we_n` is low from the second cycle of the access until it closes, and `mem_oe_n` stays high. Beats appear only on `beat_ready`, and never before cycle index max(`cfg_twc`,1).
- R6: Once past the initial latency, a beat occurs in a cycle exactly when `mem_wait_n` was high at the clock edge two edges before that cycle began, and beats remain outstanding. A low value stalls the beat and the count.
- R7: The beat count follows `req_blen`: 000→1, 001→4, 010→8, 011→16, 100→32, and 110 or 111→1.
- R8: Code 101 is an open-ended burst. Beats continue while `req_valid` is high. The first data-phase cycle with `req_valid` low carries no beat and closes the access.
- R9: After the final beat, `mem_cs_n` rises for one cycle in which `burst_done` pulses high. The controller is then idle again.
- R10: During a fixed-length burst, `req_valid`, `req_blen` and `req_addr` are ignored. `mem_addr` holds the address captured at the start, and the beat count is not affected.

Ports table follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request; for open-ended bursts held high to continue |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_blen | input | 3 | Burst length code |
| req_addr | input | ADDR_W | Start address |
| cfg_trc | input | LAT_W | Read initial latency in cycles |
| cfg_twc | input | LAT_W | Write initial latency in cycles |
| mem_wait_n | input | 1 | Memory wait, active low, one cycle early |
| mem_clk | output | 1 | Gated memory clock |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Captured burst address |
| beat_valid | output | 1 | One read beat taken this cycle |
| beat_ready | output | 1 | One write beat consumed this cycle |
| burst_done | output | 1 | Access closing this cycle |

## Verification
The assertions check every cycle that address-valid appears only alongside chip select and lasts a single cycle. They also check that read and write strobes never overlap, that output enable and write enable are never low together, and that no beat is taken while the twice-registered wait is low. Beat counts per length code, the exact cycle of the first beat after the programmed latency, and the absence of dropped or duplicated beats under random wait stretches can only be shown by the bench's bursts. The same holds for the ending of open-ended bursts and the inertness of request inputs mid-burst. The bench compares each cycle against a beat prediction built from the wait values it drove.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    localparam int CNT_W            = 6;
    localparam int WAIT_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LAT  = 2'd1,
        ST_DATA = 2'd2,
        ST_END  = 2'd3
    } sbc_state_e;

    typedef struct packed {
        logic             write;
        logic             cont;
        logic [CNT_W-1:0] beats;
    } sbc_burst_t;

    function automatic sbc_burst_t decode_burst(input logic [2:0] code, input logic wr);
        sbc_burst_t b;
        b.write = wr;
        b.cont  = 1'b0;
        case (code)
            3'd0:    b.beats = CNT_W'(1);
            3'd1:    b.beats = CNT_W'(4);
            3'd2:    b.beats = CNT_W'(8);
            3'd3:    b.beats = CNT_W'(16);
            3'd4:    b.beats = CNT_W'(32);
            3'd5: begin
                b.beats = '0;
                b.cont  = 1'b1;
            end
            default: b.beats = CNT_W'(1);
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sbc_down_ctr.sv
module sbc_down_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         zero
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (dec && (count != '0))
            count <= count - 1'b1;
    end

    assign zero = (count == '0);
endmodule

// File: rtl/sbc_wait_sync.sv
module sbc_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr <= '1;
                else     sr <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sr <= '1;
                else     sr <= {sr[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = sr[STAGES-1];
endmodule

// File: rtl/sbc_clk_gate.sv
module sbc_clk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_l;

    always_latch begin
        if (!clk) en_l = en;
    end

    assign gclk = clk & en_l;
endmodule

// File: rtl/sync_burst_ctrl.sv
module sync_burst_ctrl
    import sbc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [2:0]        req_blen,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LAT_W-1:0]  cfg_trc,
    input  logic [LAT_W-1:0]  cfg_twc,
    input  logic              mem_wait_n,
    output logic              mem_clk,
    output logic              mem_cs_n,
    output logic              mem_adv_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              beat_valid,
    output logic              beat_ready,
    output logic              burst_done
);
    sbc_state_e        state_q, state_d;
    sbc_burst_t        burst_q;
    logic [ADDR_W-1:0] addr_q;
    logic              first_q;

    logic              wait_ok;
    logic              start;
    logic              active;
    logic              stop_cont;
    logic              beat;
    logic [LAT_W-1:0]  lat_sel;
    logic [LAT_W-1:0]  lat_ld;
    logic [LAT_W-1:0]  lat_cnt;
    logic              lat_zero;
    logic [CNT_W-1:0]  beat_cnt;
    logic              beat_zero;
    logic              last_beat;
    sbc_burst_t        burst_new;

    sbc_wait_sync #(.STAGES(WAIT_SYNC_STAGES)) u_wsync (
        .clk  (clk),
        .rst  (rst),
        .din  (mem_wait_n),
        .dout (wait_ok)
    );

    assign start     = (state_q == ST_IDLE) && req_valid;
    assign active    = (state_q == ST_LAT) || (state_q == ST_DATA);
    assign burst_new = decode_burst(req_blen, req_write);
    assign lat_sel   = req_write ? cfg_twc : cfg_trc;
    assign lat_ld    = (lat_sel == '0) ? '0 : lat_sel - 1'b1;

    sbc_down_ctr #(.W(LAT_W)) u_lat (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (lat_ld),
        .dec      (state_q == ST_LAT),
        .count    (lat_cnt),
        .zero     (lat_zero)
    );

    assign stop_cont = burst_q.cont && !req_valid;
    assign beat      = (state_q == ST_DATA) && wait_ok && !stop_cont;

    sbc_down_ctr #(.W(CNT_W)) u_beats (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (burst_new.beats),
        .dec      (beat && !burst_q.cont),
        .count    (beat_cnt),
        .zero     (beat_zero)
    );

    assign last_beat = (beat_cnt == CNT_W'(1)) && !beat_zero;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start) state_d = ST_LAT;
            ST_LAT:  if (lat_zero) state_d = ST_DATA;
            ST_DATA: begin
                if (stop_cont)
                    state_d = ST_END;
                else if (beat && !burst_q.cont && last_beat)
                    state_d = ST_END;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            burst_q <= '0;
            addr_q  <= '0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            first_q <= start;
            if (start) begin
                burst_q <= burst_new;
                addr_q  <= req_addr;
            end
        end
    end

    sbc_clk_gate u_cg (
        .clk  (clk),
        .en   (active),
        .gclk (mem_clk)
    );

    assign mem_cs_n   = !active;
    assign mem_adv_n  = !first_q;
    assign mem_oe_n   = !(active && !first_q && !burst_q.write);
    assign mem_we_n   = !(active && !first_q && burst_q.write);
    assign mem_addr   = addr_q;
    assign beat_valid = beat && !burst_q.write;
    assign beat_ready = beat && burst_q.write;
    assign burst_done = (state_q == ST_END);
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker (
    input logic clk,
    input logic rst,
    input logic mem_wait_n,
    input logic mem_cs_n,
    input logic mem_adv_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic beat_valid,
    input logic beat_ready,
    input logic burst_done
);
    logic w1, w2;

    always_ff @(posedge clk) begin
        if (rst) begin
            w1 <= 1'b1;
            w2 <= 1'b1;
        end else begin
            w1 <= mem_wait_n;
            w2 <= w1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        mem_cs_n |-> (mem_adv_n && mem_oe_n && mem_we_n && !beat_valid && !beat_ready));

    assert_adv_with_cs_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_adv_n |-> !mem_cs_n);

    assert_adv_single_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_adv_n |=> mem_adv_n);

    assert_enables_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(beat_valid && beat_ready));

    assert_no_beat_in_wait_R6: assert property (@(posedge clk) disable iff (rst)
        (beat_valid || beat_ready) |-> w2);

    assert_done_closed_R9: assert property (@(posedge clk) disable iff (rst)
        burst_done |-> mem_cs_n);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        burst_done |=> !burst_done);
endmodule

bind sync_burst_ctrl sbc_checker u_chk (.*);

// File: tb/sim_sync_burst_ctrl.sv
module sim_sync_burst_ctrl;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [2:0]    req_blen = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    cfg_trc = 4'd3;
    logic [3:0]    cfg_twc = 4'd3;
    logic          mem_wait_n = 1'b1;
    logic          mem_clk, mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n;
    logic [AW-1:0] mem_addr;
    logic          beat_valid, beat_ready, burst_done;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  rand_wait = 1'b0;
    bit  mon_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic d1 = 1'b1, d2 = 1'b1;
    logic prev_act = 1'b0;

    always #5 clk = ~clk;

    sync_burst_ctrl #(.ADDR_W(AW), .LAT_W(4)) u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // wait pattern generator and its two-edge delayed mirror
    always @(posedge clk) begin
        if (rst) begin
            d1 <= 1'b1;
            d2 <= 1'b1;
        end else begin
            d1 <= mem_wait_n;
            d2 <= d1;
        end
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_wait_n = rand_wait ? !(lfsr[0] & lfsr[3]) : 1'b1;
    end

    always @(negedge clk) prev_act <= !mem_cs_n;

    // R2: gated clock follows the access state of the closing cycle
    always @(posedge clk) begin
        #2;
        if (mon_on) chk(mem_clk == prev_act, "R2 mem_clk gating", int'(mem_clk), int'(prev_act));
    end

    function automatic int beats_of(input logic [2:0] c);
        if (c == 3'd0) return 1;
        if (c >= 3'd1 && c <= 3'd4) return 4 << (c - 1);
        return 1;
    endfunction

    task automatic run_burst(input bit wr, input logic [2:0] code, input logic [3:0] lat,
                             input bit cont, input int k);
        int n_exp, eff, idx, beats, first_idx;
        bit fin, act, exp_b;
        logic [AW-1:0] a;
        n_exp = cont ? k : beats_of(code);
        eff   = (lat == 0) ? 1 : int'(lat);
        a     = {8'h5A, 5'd0, wr, code, lat, 4'h3};
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_write = wr;
        req_blen  = code;
        req_addr  = a;
        cfg_trc   = wr ? 4'd9 : lat;
        cfg_twc   = wr ? lat : 4'd9;
        @(posedge clk); #1;
        if (!cont) begin
            req_blen = ~code;   // R10: ignored mid-burst
            req_addr = ~a;
        end
        idx = 0; beats = 0; fin = 0; first_idx = -1;
        while (!fin) begin
            @(negedge clk);
            act   = beat_valid | beat_ready;
            exp_b = (idx >= eff) && d2 && (cont ? req_valid : (beats < n_exp));
            chk(act == exp_b, cont ? "R8 beat timing" : "R6/R7 beat timing", int'(act), int'(exp_b));
            if (act) chk(wr ? (beat_ready && !beat_valid) : (beat_valid && !beat_ready),
                         wr ? "R5 write strobe" : "R4 read strobe", int'(beat_valid), int'(!wr));
            if (act && first_idx < 0) first_idx = idx;
            if (burst_done) begin
                fin = 1;
                chk(mem_cs_n == 1'b1, "R9 cs released at done", int'(mem_cs_n), 1);
                chk(beats == n_exp, cont ? "R8 beat count" : "R7 beat count", beats, n_exp);
                if (!cont) req_valid = 1'b0;
            end else begin
                chk(mem_cs_n == 1'b0, "R3 cs held during access", int'(mem_cs_n), 0);
                chk(mem_adv_n == (idx != 0), "R3 adv pulse", int'(mem_adv_n), int'(idx != 0));
                chk(mem_addr == a, "R10 address held", int'(mem_addr), int'(a));
                if (wr) begin
                    chk(mem_we_n == (idx == 0) && mem_oe_n, "R5 we_n window", int'(mem_we_n), int'(idx == 0));
                end else begin
                    chk(mem_oe_n == (idx == 0) && mem_we_n, "R4 oe_n window", int'(mem_oe_n), int'(idx == 0));
                end
            end
            if (act) beats++;
            if (cont && act && beats == k && req_valid) begin
                @(posedge clk); #1;
                req_valid = 1'b0;
            end
            idx++;
            if (idx > 800) begin
                chk(1'b0, "R9 burst never closed", idx, 0);
                fin = 1;
                req_valid = 1'b0;
            end
        end
        if (!rand_wait)
            chk(first_idx == eff, wr ? "R5 first write beat latency" : "R4 first read beat latency",
                first_idx, eff);
        @(negedge clk);
        chk(mem_cs_n && !burst_done, "R9 idle after done", int'(mem_cs_n), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(mem_cs_n && mem_adv_n && mem_oe_n && mem_we_n, "R1 reset pins high", int'(mem_cs_n), 1);
        chk(!beat_valid && !beat_ready && !burst_done, "R1 reset strobes low", int'(beat_valid), 0);
        mon_on = 1'b1;
        repeat (3) @(posedge clk);
        #2 chk(mem_clk == 1'b0, "R1 idle clock low", int'(mem_clk), 0);
        for (int r = 0; r < 2; r++) begin
            rand_wait = (r == 1);
            for (int w = 0; w < 2; w++)
                for (int c = 0; c < 8; c++)
                    if (c != 5)
                        for (int l = 0; l < 4; l++)
                            run_burst(w[0], 3'(c), 4'(l * 2), 1'b0, 0);
        end
        for (int w = 0; w < 2; w++) begin
            rand_wait = 1'b0;
            run_burst(w[0], 3'd5, 4'd3, 1'b1, 3);
            rand_wait = 1'b1;
            run_burst(w[0], 3'd5, 4'd4, 1'b1, 9);
            run_burst(w[0], 3'd5, 4'd1, 1'b1, 40);
        end
        rand_wait = 1'b0;
        repeat (4) @(posedge clk);
        #2 chk(mem_clk == 1'b0 && mem_cs_n, "R1 idle after traffic", int'(mem_clk), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule